// File: doc/BRIEF.md
# Scalar half-precision fused multiply-add unit

The unit computes one IEEE binary16 fused multiply-add on the low 16-bit lane of a 128-bit vector destination. It takes three 128-bit source registers: the destination, which is also the first source, plus a second and a third source. An operand-order select decides which two lanes are multiplied and which lane is the addend. A negate flag inverts the sign of the exact product before the addend is added. The product and the sum are formed exactly and are rounded to binary16 only once. Subnormal results are produced normally and are never flushed to zero.

The rounding mode is either a static override carried with the operation or the default mode held in a control register. The low lane of the result is written, merged with the old destination value, or cleared, depending on a mask bit, a mask-present flag and a zeroing flag. Bits above the low lane always pass through from the destination. The merged result and five exception flags are registered, so they appear one clock after the inputs. The flags are invalid, denormal operand, overflow, underflow and inexact.

Top module: `fma16_unit`

## Requirements
- R1: The order select picks the multiplicands and the addend from the low lanes: 2'b00 gives dst×src3+src2, 2'b01 gives src2×dst+src3, and 2'b10 and 2'b11 both give src2×src3+dst.
- R2: For finite operands the result is the exact value of product plus addend, rounded once to binary16. Results below the normal range are delivered as subnormals.
- R3: When negate is 1, only the sign of the product is inverted; the sign of the addend is never changed.
- R4: The rounding mode is the static override field when rc_en is 1 and src3_reg is 1, and rm_dflt otherwise. Encoding: 00 nearest-even, 01 toward −∞, 10 toward +∞, 11 toward zero.
- R5: The low lane takes the computed value when mask_bit is 1 or mask_on is 0. Otherwise it is 16'h0000 if zero_mask is 1 and the old dst low lane if zero_mask is 0, and all five flags read 0.
- R6: Result bits 127:16 always equal dst bits 127:16.
- R7: A NaN operand, ∞×0, or an infinite product plus an opposite-signed infinite addend sets flag bit 0 (invalid). A NaN operand returns the first NaN among multiplicand 1, multiplicand 2 and the addend, with bit 9 forced to 1. The other two cases return 16'h7E00.
- R8: With no invalid case, an infinite product or an infinite addend returns an infinity of that sign, and bits 2, 3 and 4 stay 0.
- R9: A finite result whose magnitude rounds, with an unbounded exponent, beyond 65504 sets flag bits 2 (overflow) and 4 (inexact). It returns infinity in nearest-even mode and when rounding away from zero, and 16'h7BFF with the result's sign otherwise.
- R10: Flag bit 4 (inexact) is set when the rounded result differs from the exact value. Flag bit 3 (underflow) is set when the result is inexact and the exact nonzero magnitude is below 2^-14.
- R11: An exact zero sum returns +0, or −0 in toward −∞ mode. When product and addend are zeros of the same sign, that sign is kept.
- R12: Flag bit 1 (denormal) is set when any of the three low-lane operands has a zero exponent field and a nonzero fraction.
- R13: The result and flags update one clock after the inputs are applied. While reset is held, both read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dst | input | 128 | Destination register, also the first source |
| src2 | input | 128 | Second source register |
| src3 | input | 128 | Third source register |
| order | input | 2 | Operand-order select |
| negate | input | 1 | Invert the product sign |
| rc_static | input | 2 | Static rounding-mode override |
| rc_en | input | 1 | Static override enable |
| src3_reg | input | 1 | Third source is a register |
| rm_dflt | input | 2 | Default rounding mode from the control register |
| mask_bit | input | 1 | Mask bit 0 |
| mask_on | input | 1 | A mask is in use |
| zero_mask | input | 1 | Zeroing (1) or merging (0) when masked off |
| result | output | 128 | Merged result register |
| flags | output | 5 | Bit 0 invalid, 1 denormal, 2 overflow, 3 underflow, 4 inexact |

## Verification
Some properties are checked on every clock. The assertions check that the upper bits pass through, and that masked-off lanes merge or clear with all flags quiet. They also check that an invalid flag comes with a NaN result, and that overflow or underflow always comes with inexact. Whether a value is correctly rounded can only be shown by the bench. It sweeps every combination of sixteen characteristic operands, including zeros, subnormals, extremes, infinities and NaNs, across all four rounding modes and varied orderings. Each case is compared against an exact integer model that finds the two neighbouring binary16 values by search. The operand routing, the choice of rounding source and the zero-sign rules are shown by directed cases with hand-computed values.

// File: rtl/fma16_pkg.sv
package fma16_pkg;
  localparam int FW   = 16;
  localparam int EW   = 5;
  localparam int MW   = 10;
  localparam int SUMW = 82;  // exact sum, LSB weight 2^-48
  localparam int NFL  = 5;
  localparam int FL_INV = 0;
  localparam int FL_DEN = 1;
  localparam int FL_OVF = 2;
  localparam int FL_UNF = 3;
  localparam int FL_INX = 4;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef struct packed {
    logic          sgn;
    logic [EW-1:0] ex;
    logic [MW-1:0] fr;
    logic          sub;
    logic          inf;
    logic          nan;
  } fp_cls_t;

  function automatic fp_cls_t classify(input logic [FW-1:0] x);
    fp_cls_t c;
    c.sgn = x[FW-1];
    c.ex  = x[FW-2:MW];
    c.fr  = x[MW-1:0];
    c.sub = (c.ex == '0) && (c.fr != '0);
    c.inf = (c.ex == '1) && (c.fr == '0);
    c.nan = (c.ex == '1) && (c.fr != '0);
    return c;
  endfunction
endpackage

// File: rtl/fma16_rst_sync.sv
module fma16_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_s = chain[STAGES-1];
endmodule

// File: rtl/fma16_route.sv
module fma16_route
  import fma16_pkg::*;
(
  input  logic [FW-1:0] d_lane,
  input  logic [FW-1:0] s2_lane,
  input  logic [FW-1:0] s3_lane,
  input  logic [1:0]    order,
  input  logic [1:0]    rc_static,
  input  logic          rc_en,
  input  logic          src3_reg,
  input  logic [1:0]    rm_dflt,
  output logic [FW-1:0] mul_a,
  output logic [FW-1:0] mul_b,
  output logic [FW-1:0] addend,
  output rmode_e        rmode
);
  always_comb begin
    case (order)
      2'b00: begin mul_a = d_lane;  mul_b = s3_lane; addend = s2_lane; end
      2'b01: begin mul_a = s2_lane; mul_b = d_lane;  addend = s3_lane; end
      default: begin mul_a = s2_lane; mul_b = s3_lane; addend = d_lane; end
    endcase
  end

  assign rmode = rmode_e'((rc_en && src3_reg) ? rc_static : rm_dflt);
endmodule

// File: rtl/fma16_core.sv
module fma16_core
  import fma16_pkg::*;
(
  input  logic [FW-1:0]  op_a,
  input  logic [FW-1:0]  op_b,
  input  logic [FW-1:0]  op_c,
  input  logic           negate,
  input  rmode_e         rmode,
  output logic [FW-1:0]  res,
  output logic [NFL-1:0] flg
);
  fp_cls_t ca, cb, cc;
  assign ca = classify(op_a);
  assign cb = classify(op_b);
  assign cc = classify(op_c);

  // significands with hidden bit, effective exponents (subnormal -> 1)
  logic [MW:0]   sig_a, sig_b, sig_c;
  logic [EW-1:0] ea, eb, ec;
  assign sig_a = {ca.ex != '0, ca.fr};
  assign sig_b = {cb.ex != '0, cb.fr};
  assign sig_c = {cc.ex != '0, cc.fr};
  assign ea = (ca.ex == '0) ? EW'(1) : ca.ex;
  assign eb = (cb.ex == '0) ? EW'(1) : cb.ex;
  assign ec = (cc.ex == '0) ? EW'(1) : cc.ex;

  // exact fixed-point operands, LSB weight 2^-48
  logic [2*MW+1:0] prod;
  logic [5:0]      psh, csh;
  logic [SUMW-1:0] pfix, cfix, sum;
  logic            psgn, same, ssgn;
  assign prod = sig_a * sig_b;
  assign psh  = {1'b0, ea} + {1'b0, eb} - 6'd2;
  assign csh  = {1'b0, ec} + 6'd23;
  assign pfix = SUMW'(prod) << psh;
  assign cfix = SUMW'(sig_c) << csh;
  assign psgn = ca.sgn ^ cb.sgn ^ negate;
  assign same = (psgn == cc.sgn);

  always_comb begin
    if (same) begin
      sum = pfix + cfix;  ssgn = psgn;
    end else if (pfix >= cfix) begin
      sum = pfix - cfix;  ssgn = psgn;
    end else begin
      sum = cfix - pfix;  ssgn = cc.sgn;
    end
  end

  // leading one and rounding position
  logic [6:0] lead, lsb_idx;
  always_comb begin
    lead = '0;
    for (int i = 0; i < SUMW; i++)
      if (sum[i]) lead = 7'(i);
  end
  assign lsb_idx = (lead >= 7'd34) ? lead - 7'd10 : 7'd24;

  logic [MW:0]   q;
  logic          guard, sticky, inc, away, ovf, tiny;
  logic [MW+1:0] qr;
  logic [16:0]   enc;
  assign q      = (MW+1)'(sum >> lsb_idx);
  assign guard  = sum[lsb_idx - 7'd1];
  assign sticky = |(sum & ((SUMW'(1) << (lsb_idx - 7'd1)) - SUMW'(1)));

  always_comb begin
    case (rmode)
      RM_NEAR: inc = guard & (sticky | q[0]);
      RM_DOWN: inc = (guard | sticky) & ssgn;
      RM_UP:   inc = (guard | sticky) & ~ssgn;
      default: inc = 1'b0;
    endcase
  end

  assign qr   = {1'b0, q} + {{MW+1{1'b0}}, inc};
  assign enc  = ((17'(lsb_idx) - 17'd24) << MW) + 17'(qr);
  assign ovf  = (enc >= 17'h7C00);
  assign tiny = (lead < 7'd34);
  assign away = (rmode == RM_NEAR) || (rmode == RM_UP && !ssgn) ||
                (rmode == RM_DOWN && ssgn);

  // special operands
  logic a_zero, b_zero, any_nan, prod_inf, inv_mul, inv_add, finite;
  logic [FW-1:0] nan_pick;
  assign a_zero   = (ca.ex == '0) && (ca.fr == '0);
  assign b_zero   = (cb.ex == '0) && (cb.fr == '0);
  assign any_nan  = ca.nan | cb.nan | cc.nan;
  assign prod_inf = ca.inf | cb.inf;
  assign inv_mul  = (ca.inf & b_zero) | (cb.inf & a_zero);
  assign inv_add  = prod_inf & cc.inf & (psgn != cc.sgn);
  assign finite   = !(any_nan | inv_mul | prod_inf | cc.inf);
  assign nan_pick = ca.nan ? op_a : (cb.nan ? op_b : op_c);

  always_comb begin
    if (any_nan)                res = nan_pick | 16'h0200;
    else if (inv_mul | inv_add) res = 16'h7E00;
    else if (prod_inf)          res = {psgn, 15'h7C00};
    else if (cc.inf)            res = {cc.sgn, 15'h7C00};
    else if (sum == '0)         res = {same ? psgn : (rmode == RM_DOWN), 15'h0};
    else if (ovf)               res = {ssgn, away ? 15'h7C00 : 15'h7BFF};
    else                        res = {ssgn, enc[14:0]};
  end

  always_comb begin
    flg         = '0;
    flg[FL_INV] = any_nan | inv_mul | inv_add;
    flg[FL_DEN] = ca.sub | cb.sub | cc.sub;
    flg[FL_OVF] = finite & ovf;
    flg[FL_INX] = finite & (guard | sticky | ovf);
    flg[FL_UNF] = finite & tiny & (guard | sticky);
  end
endmodule

// File: rtl/fma16_unit.sv
module fma16_unit
  import fma16_pkg::*;
#(
  parameter int VW = 128
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [VW-1:0]  dst,
  input  logic [VW-1:0]  src2,
  input  logic [VW-1:0]  src3,
  input  logic [1:0]     order,
  input  logic           negate,
  input  logic [1:0]     rc_static,
  input  logic           rc_en,
  input  logic           src3_reg,
  input  logic [1:0]     rm_dflt,
  input  logic           mask_bit,
  input  logic           mask_on,
  input  logic           zero_mask,
  output logic [VW-1:0]  result,
  output logic [NFL-1:0] flags
);
  logic          rst_s;
  logic [FW-1:0] mul_a, mul_b, addend, core_res, lane_nx;
  logic [NFL-1:0] core_flg, flg_nx;
  logic [VW-1:0] res_nx;
  logic          lane_we;
  rmode_e        rmode;

  fma16_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_s(rst_s));

  fma16_route u_route (
    .d_lane(dst[FW-1:0]), .s2_lane(src2[FW-1:0]), .s3_lane(src3[FW-1:0]),
    .order(order), .rc_static(rc_static), .rc_en(rc_en), .src3_reg(src3_reg),
    .rm_dflt(rm_dflt), .mul_a(mul_a), .mul_b(mul_b), .addend(addend), .rmode(rmode)
  );

  fma16_core u_core (
    .op_a(mul_a), .op_b(mul_b), .op_c(addend), .negate(negate),
    .rmode(rmode), .res(core_res), .flg(core_flg)
  );

  // next-state: lane masking and upper-bit passthrough
  always_comb begin
    lane_we = mask_bit | ~mask_on;
    if (lane_we)        lane_nx = core_res;
    else if (zero_mask) lane_nx = '0;
    else                lane_nx = dst[FW-1:0];
    flg_nx = lane_we ? core_flg : '0;
    res_nx = {dst[VW-1:FW], lane_nx};
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      result <= '0;
      flags  <= '0;
    end else begin
      result <= res_nx;
      flags  <= flg_nx;
    end
  end

  // R6
  a_r6_upper_kept: assert property (@(posedge clk) disable iff (!rst_s)
    rst_s |=> result[VW-1:FW] == $past(dst[VW-1:FW]));
  // R5
  a_r5_merge_keeps: assert property (@(posedge clk) disable iff (!rst_s)
    (mask_on && !mask_bit && !zero_mask) |=> result[FW-1:0] == $past(dst[FW-1:0]));
  a_r5_zero_clears: assert property (@(posedge clk) disable iff (!rst_s)
    (mask_on && !mask_bit && zero_mask) |=> result[FW-1:0] == '0);
  a_r5_flags_quiet: assert property (@(posedge clk) disable iff (!rst_s)
    (mask_on && !mask_bit) |=> flags == '0);
  // R7
  a_r7_invalid_nan: assert property (@(posedge clk) disable iff (!rst_s)
    flags[FL_INV] |-> (result[14:10] == 5'h1F) && (result[9:0] != '0));
  // R9
  a_r9_ovf_inexact: assert property (@(posedge clk) disable iff (!rst_s)
    flags[FL_OVF] |-> flags[FL_INX]);
  // R10
  a_r10_unf_inexact: assert property (@(posedge clk) disable iff (!rst_s)
    flags[FL_UNF] |-> flags[FL_INX]);
endmodule

// File: tb/fma16_unit_test.sv
`timescale 1ns/1ps
module fma16_unit_test;
  logic clk = 1'b0;
  logic rst_n;
  logic [127:0] dst, src2, src3;
  logic [1:0] order, rc_static, rm_dflt;
  logic negate, rc_en, src3_reg, mask_bit, mask_on, zero_mask;
  logic [127:0] result;
  logic [4:0] flags;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  fma16_unit uut (
    .clk(clk), .rst_n(rst_n), .dst(dst), .src2(src2), .src3(src3),
    .order(order), .negate(negate), .rc_static(rc_static), .rc_en(rc_en),
    .src3_reg(src3_reg), .rm_dflt(rm_dflt), .mask_bit(mask_bit),
    .mask_on(mask_on), .zero_mask(zero_mask), .result(result), .flags(flags)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // value * 2^24 of a finite binary16 magnitude
  function automatic logic [127:0] fix24(input logic [15:0] x);
    if (x[14:10] == 0) return 128'(x[9:0]);
    return 128'(11'd1024 + 11'(x[9:0])) << (x[14:10] - 5'd1);
  endfunction

  function automatic logic isnan16(input logic [15:0] x);
    return (&x[14:10]) && (|x[9:0]);
  endfunction
  function automatic logic isinf16(input logic [15:0] x);
    return (&x[14:10]) && (x[9:0] == 0);
  endfunction
  function automatic logic iszero16(input logic [15:0] x);
    return x[14:0] == 0;
  endfunction

  // exact reference: flags {inx,unf,ovf,den,inv}
  task automatic ref_fma(input logic [15:0] a, b, c, input logic ng, input logic [1:0] rm,
                         output logic [15:0] r, output logic [4:0] f);
    logic ps, cs, sx, up, exact, ovf, awy;
    logic [127:0] p, cv, x, vk, vu, big;
    logic [15:0] lo, hi, mid, k;
    f = '0;
    f[1] = (a[14:10] == 0 && a[9:0] != 0) || (b[14:10] == 0 && b[9:0] != 0) ||
           (c[14:10] == 0 && c[9:0] != 0);
    ps = a[15] ^ b[15] ^ ng;
    cs = c[15];
    if (isnan16(a) || isnan16(b) || isnan16(c)) begin
      f[0] = 1'b1;
      r = (isnan16(a) ? a : isnan16(b) ? b : c) | 16'h0200;
    end else if ((isinf16(a) && iszero16(b)) || (isinf16(b) && iszero16(a)) ||
                 ((isinf16(a) || isinf16(b)) && isinf16(c) && ps != cs)) begin
      f[0] = 1'b1;
      r = 16'h7E00;
    end else if (isinf16(a) || isinf16(b)) begin
      r = {ps, 15'h7C00};
    end else if (isinf16(c)) begin
      r = {cs, 15'h7C00};
    end else begin
      p  = fix24(a) * fix24(b);
      cv = fix24(c) << 24;
      if (ps == cs) begin x = p + cv; sx = ps; end
      else if (p >= cv) begin x = p - cv; sx = ps; end
      else begin x = cv - p; sx = cs; end
      if (x == 0) begin
        r = {(ps == cs) ? ps : (rm == 2'b01), 15'h0};
      end else begin
        big = 128'd65536 << 48;
        lo = 16'h0000; hi = 16'h7BFF;
        if ((fix24(hi) << 24) <= x) lo = hi;
        else while (lo < hi) begin
          mid = (lo + hi + 16'd1) >> 1;
          if ((fix24(mid) << 24) <= x) lo = mid; else hi = mid - 16'd1;
        end
        k = lo;
        vk = fix24(k) << 24;
        vu = (k == 16'h7BFF) ? big : (fix24(k + 16'd1) << 24);
        exact = (vk == x);
        awy = (rm == 2'b10 && !sx) || (rm == 2'b01 && sx);
        if (rm == 2'b00) up = (2 * x > vk + vu) || ((2 * x == vk + vu) && k[0]);
        else if (awy)    up = !exact;
        else             up = 1'b0;
        ovf = (x >= big) || (up && k == 16'h7BFF);
        if (ovf) r = {sx, (rm == 2'b00 || awy) ? 15'h7C00 : 15'h7BFF};
        else     r = {sx, up ? 15'(k + 16'd1) : 15'(k)};
        f[2] = ovf;
        f[4] = !exact || ovf;
        f[3] = !exact && (x < (128'd1 << 34));
      end
    end
  endtask

  // drive at negedge, check result at the following negedge
  task automatic apply(input string tag, input logic [127:0] d, s2, s3,
                       input logic [1:0] od, input logic ng, input logic [1:0] rcs,
                       input logic rce, s3r, input logic [1:0] rmd,
                       input logic mb, mo, zm);
    logic [15:0] a, b, c, r, lane;
    logic [4:0] f, ef;
    logic [1:0] rm;
    string t;
    dst = d; src2 = s2; src3 = s3; order = od; negate = ng; rc_static = rcs;
    rc_en = rce; src3_reg = s3r; rm_dflt = rmd; mask_bit = mb; mask_on = mo;
    zero_mask = zm;
    case (od)
      2'b00: begin a = d[15:0];  b = s3[15:0]; c = s2[15:0]; end
      2'b01: begin a = s2[15:0]; b = d[15:0];  c = s3[15:0]; end
      default: begin a = s2[15:0]; b = s3[15:0]; c = d[15:0]; end
    endcase
    rm = (rce && s3r) ? rcs : rmd;
    ref_fma(a, b, c, ng, rm, r, f);
    if (mb || !mo) begin lane = r; ef = f; end
    else begin lane = zm ? 16'h0 : d[15:0]; ef = '0; end
    @(posedge clk);
    @(negedge clk);
    if (tag != "") t = tag;
    else if (!(mb || !mo)) t = "R5";
    else if (f[0]) t = "R7";
    else if (isinf16(r) && !f[2]) t = "R8";
    else if (f[2]) t = "R9";
    else if (iszero16(r)) t = "R11";
    else if (f[3]) t = "R10";
    else t = "R2";
    chk({t, " lane"}, 128'(result[15:0]), 128'(lane));
    chk(f[1] ? "R12 flags" : {t, " flags"}, 128'(flags), 128'(ef));
    chk("R6 upper", 128'(result[127:16]), 128'(d[127:16]));
  endtask

  function automatic logic [15:0] pickval(input int i);
    case (i)
      0: return 16'h0000;  1: return 16'h8000;  2: return 16'h0001;  3: return 16'h03FF;
      4: return 16'h0400;  5: return 16'h3C00;  6: return 16'hBC00;  7: return 16'h3C01;
      8: return 16'h7BFF;  9: return 16'hFBFF; 10: return 16'h7C00; 11: return 16'hFC00;
      12: return 16'h7E00; 13: return 16'h7D00; 14: return 16'h3555; default: return 16'hC200;
    endcase
  endfunction

  initial begin
    int lim = 150000;
    repeat (lim) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R13 watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] up;
    rst_n = 1'b0;
    dst = '0; src2 = '0; src3 = '0; order = '0; negate = 0; rc_static = '0;
    rc_en = 0; src3_reg = 0; rm_dflt = '0; mask_bit = 0; mask_on = 0; zero_mask = 0;
    repeat (3) @(negedge clk);
    chk("R13 reset result", result, '0);
    chk("R13 reset flags", 128'(flags), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    up = 128'hA5A5_0F0F_1234_5678_9ABC_DEF0_CAFE_0000;

    // R1 operand orders: 2,3,5 -> 13, 11, 17, 17
    apply("R1", up | 128'h4000, 128'h4200, 128'h4500, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 132", 128'(result[15:0]), 128'h4A80);
    apply("R1", up | 128'h4000, 128'h4200, 128'h4500, 2'b01, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 213", 128'(result[15:0]), 128'h4980);
    apply("R1", up | 128'h4000, 128'h4200, 128'h4500, 2'b10, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 231", 128'(result[15:0]), 128'h4C40);
    // R13 latency: new inputs not visible before the clock edge
    dst = 128'h0; src2 = 128'h3C00; src3 = 128'h3C00; order = 2'b10;
    #1 chk("R13 hold before edge", 128'(result[15:0]), 128'h4C40);
    apply("R1", up | 128'h4000, 128'h4200, 128'h4500, 2'b11, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 order3", 128'(result[15:0]), 128'h4C40);
    // R3 negated product: -(2*5)+3 = -7
    apply("R3", 128'h4000, 128'h4200, 128'h4500, 2'b00, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 negate", 128'(result[15:0]), 128'hC700);
    // R4 rounding source: 1*1 + 2^-24
    apply("R4", 128'h0001, 128'h3C00, 128'h3C00, 2'b10, 0, 2'b10, 1, 1, 2'b00, 0, 0, 0);
    chk("R4 static up", 128'(result[15:0]), 128'h3C01);
    apply("R4", 128'h0001, 128'h3C00, 128'h3C00, 2'b10, 0, 2'b10, 1, 0, 2'b00, 0, 0, 0);
    chk("R4 memory operand uses default", 128'(result[15:0]), 128'h3C00);
    apply("R4", 128'h0001, 128'h3C00, 128'h3C00, 2'b10, 0, 2'b00, 0, 1, 2'b10, 0, 0, 0);
    chk("R4 default up", 128'(result[15:0]), 128'h3C01);
    // R5 masking with an invalid computation in the lane
    apply("R5", up | 128'h1234, 128'h7C00, 128'h0000, 2'b00, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R5 merge", 128'(result[15:0]), 128'h1234);
    chk("R5 merge flags", 128'(flags), 128'h0);
    apply("R5", up | 128'h0000, 128'h7C00, 128'h0000, 2'b10, 0, 0, 0, 0, 0, 0, 1, 1);
    chk("R5 zero", 128'(result[15:0]), 128'h0);
    apply("R5", up | 128'h0000, 128'h7C00, 128'h0000, 2'b10, 0, 0, 0, 0, 0, 1, 1, 1);
    chk("R5 written", 128'(result[15:0]), 128'h7E00);
    chk("R7 inf times zero flags", 128'(flags), 128'h01);
    // R7 signalling NaN quieted
    apply("R7", 128'h7C00, 128'h7D00, 128'h3C00, 2'b10, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 nan", 128'(result[15:0]), 128'h7F00);
    // R8 infinities
    apply("R8", 128'hFC00, 128'h7C00, 128'h3C00, 2'b10, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 inf minus inf", 128'(result[15:0]), 128'h7E00);
    apply("R8", 128'hFC00, 128'h7C00, 128'hBC00, 2'b10, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 same inf", 128'(result[15:0]), 128'hFC00);
    // R9 overflow
    apply("R9", 128'h0000, 128'h7BFF, 128'h4000, 2'b10, 0, 2'b11, 1, 1, 0, 0, 0, 0);
    chk("R9 toward zero", 128'(result[15:0]), 128'h7BFF);
    chk("R9 flags", 128'(flags), 128'h14);
    apply("R9", 128'h0000, 128'h7BFF, 128'h4000, 2'b10, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 nearest", 128'(result[15:0]), 128'h7C00);
    // R10 tie into subnormal range
    apply("R10", 128'h0000, 128'h0401, 128'h3800, 2'b10, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 value", 128'(result[15:0]), 128'h0200);
    chk("R10 flags", 128'(flags), 128'h18);
    // R11 zero signs
    apply("R11", 128'hBC00, 128'h3C00, 128'h3C00, 2'b10, 0, 0, 0, 0, 2'b00, 0, 0, 0);
    chk("R11 plus zero", 128'(result[15:0]), 128'h0000);
    apply("R11", 128'hBC00, 128'h3C00, 128'h3C00, 2'b10, 0, 0, 0, 0, 2'b01, 0, 0, 0);
    chk("R11 minus zero", 128'(result[15:0]), 128'h8000);
    apply("R11", 128'h8000, 128'h8000, 128'h3C00, 2'b10, 0, 0, 0, 0, 2'b00, 0, 0, 0);
    chk("R11 kept sign", 128'(result[15:0]), 128'h8000);
    // R12 denormal operand
    apply("R12", 128'h0000, 128'h03FF, 128'h3C00, 2'b10, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R12 flags", 128'(flags), 128'h02);

    // R2 sweep: all operand triples over all rounding modes
    for (int ia = 0; ia < 16; ia++)
      for (int ib = 0; ib < 16; ib++)
        for (int ic = 0; ic < 16; ic++)
          for (int m = 0; m < 4; m++)
            apply("", up ^ 128'(pickval(ia)), 128'(pickval(ib)), 128'(pickval(ic)),
                  2'((ia + ib + ic + m) % 3), 1'(m ^ ic), 0, 0, 0, 2'(m), 0, 0, 0);

    // R2 random vectors with random control
    for (int n = 0; n < 20000; n++) begin
      logic [31:0] w0, w1, w2, w3;
      w0 = rnd(); w1 = rnd(); w2 = rnd(); w3 = rnd();
      apply("", {w0, w1, w2, w3}, {w1, w3, w0, rnd()}, {w2, w0, w3, rnd()},
            w0[1:0], w1[0], w2[1:0], w3[0], w3[1], w1[2:1], w2[3] | w2[4], w3[2], w0[3]);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule